// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM with a 32-bit word. The depth is set by the address width parameter. A width of 17 gives the full 128K-word array. The default is kept smaller so that elaboration stays light. The address, the control inputs and the write data are captured on the rising clock edge.

A read returns its word two edges after the edge that captured it. An internal counter turns one loaded start address into a burst of four beats. The caller picks the beat order, linear or interleaved, at load time. Writes are self-timed and take effect on the edge after capture. Each of four lane enables writes one byte. A global write enable writes the whole word whatever the lane enables say.

A sleep input stops all accesses and drives the read port to zero. The stored contents are kept while it is high. Read and write data use separate ports; there is no output enable and no bidirectional bus.

Top module: `burst_sram`

## Requirements
- R1: While `rst` is high at a rising edge, `rdata` becomes 0 and no access stays pending. After reset, no read or write happens until a `load` or `adv` is captured.
- R2: A read captured at edge N puts its word on `rdata` just after edge N+2. `rdata` does not change at edge N+1 because of that read.
- R3: `load` high at an edge (with `sleep` low) starts a new burst at beat 0 from `addr_in`, even in the middle of a burst. `load` takes priority over `adv`.
- R4: `adv` high without `load` steps the beat by one, modulo 4, and issues an access at the new beat. With neither input high, no access is issued, `rdata` holds its value and the burst position is kept.
- R5: When `order_sel` is 0 at load, beat k addresses the start address with its two low bits replaced by (low bits + k) mod 4. The upper bits are unchanged.
- R6: When `order_sel` is 1 at load, beat k addresses the start address with its two low bits XORed with k.
- R7: An access is a write when `gwe` is 1 or any `bwe` bit is 1, and a read otherwise. `bwe[i]` writes `wdata[8i+7:8i]` and leaves the other lanes unchanged.
- R8: With `gwe` at 1, all 32 bits are written, whatever the value of `bwe`.
- R9: A write leaves `rdata` unchanged. A read that follows a write to the same address on the next edge returns the new data.
- R10: With `sleep` high at an edge: no access is captured, any access waiting in the pipeline is dropped, `rdata` becomes 0, and the burst position is held. The array contents are kept.
- R11: At the first edge with `sleep` low again, `load` and `adv` are captured as normal. A later read returns the data written before sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sleep | input | 1 | Power-down request, active high |
| order_sel | input | 1 | Burst order taken at load: 0 linear, 1 interleaved |
| load | input | 1 | Start a burst at `addr_in` |
| adv | input | 1 | Step the burst by one beat |
| addr_in | input | ADDR_W | Start address of a burst |
| gwe | input | 1 | Write the full word |
| bwe | input | 4 | Write enable for each byte lane |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
The bench builds the block with `ADDR_W` = 6, a 64-word array. At this size, whole-array fills with bursts of writes are short. A burst that starts at the top address is also reachable, so the bench can show that the low-bit wrap never carries into the upper address bits. The small array lets the reference model keep the full memory image. Every `rdata` value is then predicted, including reads of contents kept through sleep.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

    typedef struct packed {
        logic              valid;
        logic              wr;
        logic [LANES-1:0]  mask;
        logic [WORD_W-1:0] data;
    } req_t;

    function automatic logic [1:0] beat_low(input logic [1:0] start,
                                            input logic [1:0] beat,
                                            input order_e     ord);
        return (ord == ORD_XOR) ? (start ^ beat) : (start + beat);
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input logic             all,
                                                   input logic [LANES-1:0] lanes);
        return all ? {LANES{1'b1}} : lanes;
    endfunction

endpackage

// File: rtl/burst_ctr.sv
module burst_ctr
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sleep,
    input  logic                 order_sel,
    input  logic                 load,
    input  logic                 adv,
    input  logic [ADDR_W-1:0]    addr_in,
    input  logic                 gwe,
    input  logic [LANES-1:0]     bwe,
    input  logic [WORD_W-1:0]    wdata,
    output req_t                 req,
    output logic [ADDR_W-1:0]    eff_addr
);

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        beat_q;
    order_e            ord_q;
    logic [LANES-1:0]  mask;

    assign mask = lane_mask(gwe, bwe);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            beat_q <= '0;
            ord_q  <= ORD_LINEAR;
            req    <= '0;
        end else if (sleep) begin
            req.valid <= 1'b0;
        end else begin
            if (load) begin
                base_q <= addr_in;
                beat_q <= 2'd0;
                ord_q  <= order_e'(order_sel);
            end else if (adv) begin
                beat_q <= beat_q + 2'd1;
            end
            req.valid <= load | adv;
            req.wr    <= |mask;
            req.mask  <= mask;
            req.data  <= wdata;
        end
    end

    assign eff_addr = {base_q[ADDR_W-1:2], beat_low(base_q[1:0], beat_q, ord_q)};

    a_r3_load_start: assert property (@(posedge clk) disable iff (rst)
        (load && !sleep) |=> (beat_q == 2'd0 && base_q == $past(addr_in)));
    a_r4_adv_step: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && !sleep) |=> (beat_q == $past(beat_q) + 2'd1));
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv) |=> ($stable(beat_q) && $stable(base_q) && !req.valid));
    a_r10_sleep_quiet: assert property (@(posedge clk) disable iff (rst)
        sleep |=> (!req.valid && $stable(beat_q) && $stable(base_q)));

endmodule

// File: rtl/sram_core.sv
module sram_core
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sleep,
    input  req_t                 req,
    input  logic [ADDR_W-1:0]    eff_addr,
    output logic [WORD_W-1:0]    rd_data,
    output logic                 rd_valid
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!sleep && req.valid && req.wr) begin
            for (int i = 0; i < LANES; i++) begin
                if (req.mask[i]) mem[eff_addr][8*i +: 8] <= req.data[8*i +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= !sleep && req.valid && !req.wr;
            if (!sleep && req.valid && !req.wr) rd_data <= mem[eff_addr];
        end
    end

    a_r9_write_no_read: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.wr) |=> !rd_valid);
    a_r10_sleep_drop: assert property (@(posedge clk) disable iff (rst)
        sleep |=> !rd_valid);

endmodule

// File: rtl/read_out.sv
module read_out
    import burst_sram_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sleep,
    input  logic                 rd_valid,
    input  logic [WORD_W-1:0]    rd_data,
    output logic [WORD_W-1:0]    rdata
);

    always_ff @(posedge clk) begin
        if (rst || sleep) rdata <= '0;
        else if (rd_valid) rdata <= rd_data;
    end

    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (rdata == '0));
    a_r10_sleep_zero: assert property (@(posedge clk) disable iff (rst)
        sleep |=> (rdata == '0));
    a_r2_second_stage: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !sleep) |=> (rdata == $past(rd_data)));
    a_r4_hold_out: assert property (@(posedge clk) disable iff (rst)
        (!rd_valid && !sleep) |=> $stable(rdata));

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic              order_sel,
    input  logic              load,
    input  logic              adv,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              gwe,
    input  logic [3:0]        bwe,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);

    req_t              req;
    logic [ADDR_W-1:0] eff_addr;
    logic [WORD_W-1:0] rd_data;
    logic              rd_valid;

    burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk(clk), .rst(rst), .sleep(sleep), .order_sel(order_sel),
        .load(load), .adv(adv), .addr_in(addr_in), .gwe(gwe), .bwe(bwe),
        .wdata(wdata), .req(req), .eff_addr(eff_addr)
    );

    sram_core #(.ADDR_W(ADDR_W)) u_core (
        .clk(clk), .rst(rst), .sleep(sleep), .req(req), .eff_addr(eff_addr),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    read_out u_out (
        .clk(clk), .rst(rst), .sleep(sleep), .rd_valid(rd_valid),
        .rd_data(rd_data), .rdata(rdata)
    );

endmodule

// File: tb/burst_sram_bench.sv
module burst_sram_bench;

    localparam int AW = 6;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst, sleep, order_sel, load, adv, gwe;
    logic [AW-1:0] addr_in;
    logic [3:0]    bwe;
    logic [31:0]   wdata, rdata;

    always #5 clk = ~clk;

    burst_sram #(.ADDR_W(AW)) u_burst_sram (
        .clk(clk), .rst(rst), .sleep(sleep), .order_sel(order_sel),
        .load(load), .adv(adv), .addr_in(addr_in), .gwe(gwe), .bwe(bwe),
        .wdata(wdata), .rdata(rdata)
    );

    // reference model state
    logic [31:0] mm [N];
    int          m_base, m_beat, m_mode;
    bit          m_pend, m_pwr, m_rv;
    logic [3:0]  m_pmask;
    logic [31:0] m_pdata, m_rd, m_out;

    int    n_cmp = 0, n_bad = 0;
    string tag = "R1";
    bit    done = 0;

    function automatic int beat_addr(int b, int k, int mode);
        if (mode != 0) return b ^ k;
        return (b / 4) * 4 + ((b % 4 + k) % 4);
    endfunction

    task automatic model_edge();
        int ea;
        if (rst) begin
            m_out = 0; m_rv = 0; m_pend = 0; m_base = 0; m_beat = 0; m_mode = 0;
            return;
        end
        if (sleep) m_out = 0;
        else if (m_rv) m_out = m_rd;
        m_rv = 0;
        if (!sleep && m_pend) begin
            ea = beat_addr(m_base, m_beat, m_mode);
            if (m_pwr) begin
                for (int i = 0; i < 4; i++)
                    if (m_pmask[i]) mm[ea][8*i +: 8] = m_pdata[8*i +: 8];
            end else begin
                m_rd = mm[ea];
                m_rv = 1;
            end
        end
        if (sleep) m_pend = 0;
        else begin
            if (load) begin
                m_base = int'(addr_in); m_beat = 0; m_mode = int'(order_sel);
            end else if (adv) m_beat = (m_beat + 1) % 4;
            m_pend  = load || adv;
            m_pmask = gwe ? 4'hF : bwe;
            m_pwr   = (m_pmask != 0);
            m_pdata = wdata;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        n_cmp++;
        if (rdata !== m_out) begin
            n_bad++;
            $display("FAIL %s rdata actual=%08h expected=%08h", tag, rdata, m_out);
        end
    endtask

    task automatic drv(bit l, bit a, int ad, bit g, logic [3:0] b, logic [31:0] d);
        load = l; adv = a; addr_in = AW'(ad); gwe = g; bwe = b; wdata = d;
        tick();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drv(0, 0, 0, 0, 4'h0, 32'h0);
    endtask

    task automatic read_burst(int ad, bit mode);
        order_sel = mode;
        drv(1, 0, ad, 0, 4'h0, 32'h0);
        for (int k = 0; k < 3; k++) drv(0, 1, 0, 0, 4'h0, 32'h0);
        idle(3);
    endtask

    initial begin
        rst = 1; sleep = 0; order_sel = 0; load = 0; adv = 0; gwe = 0;
        addr_in = '0; bwe = '0; wdata = '0;
        tag = "R1"; tick(); tick(); tick();
        rst = 0;
        tag = "R1"; idle(2);

        // fill array with full-word writes, bwe set to show override
        tag = "R8";
        for (int a = 0; a < N; a += 4) begin
            order_sel = 0;
            drv(1, 0, a, 1, 4'h2, 32'hA5000000 + 32'(a) * 32'h01010101);
            for (int k = 1; k < 4; k++)
                drv(0, 1, 0, 1, 4'h0, 32'hA5000000 + 32'(a + k) * 32'h01010101);
        end
        idle(2);

        tag = "R2"; read_burst(8, 0);
        tag = "R5"; read_burst(6, 0);
        tag = "R5"; read_burst(N - 1, 0);
        tag = "R6"; read_burst(6, 1);
        tag = "R6"; read_burst(N - 3, 1);

        tag = "R7";
        order_sel = 0;
        drv(1, 0, 9, 0, 4'b0101, 32'h11223344);
        drv(0, 1, 0, 0, 4'b1000, 32'hDEADBEEF);
        idle(1);
        read_burst(9, 0);

        tag = "R8";
        drv(1, 0, 20, 1, 4'b0001, 32'hCAFEF00D);
        tag = "R9";
        drv(1, 0, 20, 0, 4'h0, 32'h0);
        idle(3);

        tag = "R4";
        order_sel = 1;
        drv(1, 0, 33, 0, 4'h0, 32'h0);
        idle(2);
        drv(0, 1, 0, 0, 4'h0, 32'h0);
        idle(3);
        drv(0, 1, 0, 0, 4'h0, 32'h0);
        drv(0, 1, 0, 0, 4'h0, 32'h0);
        drv(0, 1, 0, 0, 4'h0, 32'h0);
        idle(3);

        tag = "R3";
        order_sel = 0;
        drv(1, 0, 40, 0, 4'h0, 32'h0);
        drv(0, 1, 0, 0, 4'h0, 32'h0);
        drv(1, 1, 50, 0, 4'h0, 32'h0);
        drv(0, 1, 0, 0, 4'h0, 32'h0);
        idle(3);

        tag = "R10";
        drv(1, 0, 12, 0, 4'h0, 32'h0);
        drv(0, 1, 0, 1, 4'h0, 32'h77777777);
        sleep = 1;
        drv(1, 1, 4, 1, 4'hF, 32'h0BADBAD0);
        drv(0, 1, 0, 1, 4'hF, 32'h0BADBAD1);
        idle(2);
        sleep = 0;
        tag = "R11";
        drv(0, 1, 0, 0, 4'h0, 32'h0);
        idle(3);
        read_burst(4, 0);
        read_burst(12, 0);

        tag = "R9";
        drv(1, 0, 30, 1, 4'h0, 32'h13579BDF);
        drv(1, 0, 30, 0, 4'h0, 32'h0);
        idle(3);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog run did not finish actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule